// File: doc/BRIEF.md
# Chain Response Word Checker

This block takes one 32-bit response word returned by a chain of battery-monitor devices, once the word has been fully shifted in. It checks the word's integrity by recomputing an 8-bit CRC over the upper part of the word. It then splits the word into its fields. Two field layouts are supported. The conversion layout carries a 4-bit channel code and a 12-bit measurement. The register layout carries a 6-bit register address and an 8-bit data byte. A single input picks the layout for each word.

The device address travels on the wire least-significant bit first. The block turns it back into a normal binary address before reporting it and before comparing it against the address the host expects. The returned channel or register address is also compared against the expected one. A failed CRC and a wrong address are reported as separate flags. All outputs are registered and appear one cycle after the word is presented. The decoded fields change only when a word is accepted.

Top module: `rsp_word_checker`

## Requirements
- R1: While reset is active and after reset, `res_vld`, `crc_err`, `addr_err`, `is_cell`, `dev_addr`, `sub_addr` and `data` are all zero until the first word is accepted.
- R2: A word presented with `word_vld` high in one cycle produces `res_vld` high in exactly the next cycle. `res_vld` is low in every cycle that follows a cycle with `word_vld` low, and back-to-back words give back-to-back results.
- R3: The check value is computed over bits 31:10 of the word, taken as a 22-bit number M, using the generator x^8+x^5+x^3+x^2+x+1 (0x2F) with a zero start value. It is the CRC of M[21:8], fed most-significant bit first, XORed with M[7:0]. `crc_err` is set when this value differs from word bits 9:2. Bits 1:0 and bit 10 do not affect any other output.
- R4: When `crc_err` is set, `addr_err` is low and `dev_addr`, `sub_addr`, `data` and `is_cell` are all zero for that result.
- R5: `dev_addr` is word bits 31:27 in reversed bit order: `dev_addr[4]` is word bit 27 and `dev_addr[0]` is word bit 31.
- R6: With `fmt_reg` = 0 (conversion layout), `sub_addr` = {2'b00, word[26:23]} and `data` = word[22:11].
- R7: With `fmt_reg` = 1 (register layout), `sub_addr` = word[26:21] and `data` = {4'b0000, word[20:13]}.
- R8: When the CRC is good, `addr_err` is set if `dev_addr` differs from `exp_dev`, or if the returned address differs from the expected one. In the conversion layout only `exp_addr[3:0]` is compared with the channel code. In the register layout all six bits of `exp_addr` are compared.
- R9: `is_cell` is high only for a good-CRC conversion-layout word whose channel code is 0 to 5. Codes 6 to 15 and every register-layout word give `is_cell` low.
- R10: `crc_err` and `addr_err` are high only in cycles where `res_vld` is high. The decoded fields hold their values while no word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_vld | input | 1 | A complete response word is on `word_in` this cycle |
| word_in | input | 32 | Received response word |
| fmt_reg | input | 1 | Layout select: 0 conversion, 1 register readback |
| exp_dev | input | 5 | Expected device address, normal bit order |
| exp_addr | input | 6 | Expected channel code (low 4 bits) or register address |
| res_vld | output | 1 | One-cycle strobe marking a decoded result |
| crc_err | output | 1 | CRC mismatch on the result |
| addr_err | output | 1 | Device or channel/register address mismatch (good CRC only) |
| dev_addr | output | 5 | Returned device address, normal bit order |
| sub_addr | output | 6 | Returned channel code or register address |
| data | output | 12 | Conversion result, or zero-extended register byte |
| is_cell | output | 1 | Returned channel is a cell-voltage channel |

## Verification
The assertions assume that `word_in`, `fmt_reg`, `exp_dev` and `exp_addr` are known values in every cycle where `word_vld` is high. They also assume that `word_vld` itself is never unknown once reset has been released. The bench meets this by driving every input to a defined value before reset ends and by changing inputs only on the falling clock edge. The expected values the bench uses come from its own bit-serial CRC and its own word builder, which place each field at the position stated in the requirements.

// File: rtl/rsp_chk_pkg.sv
package rsp_chk_pkg;

  localparam int WORD_W    = 32;
  localparam int DEV_W     = 5;
  localparam int CRC_W     = 8;
  localparam int CH_W      = 4;
  localparam int REG_W     = 6;
  localparam int CONV_W    = 12;
  localparam int RDAT_W    = 8;

  localparam int DEV_LSB   = WORD_W - DEV_W;   // 27
  localparam int CH_LSB    = DEV_LSB - CH_W;   // 23
  localparam int CONV_LSB  = CH_LSB - CONV_W;  // 11
  localparam int REG_LSB   = DEV_LSB - REG_W;  // 21
  localparam int RDAT_LSB  = REG_LSB - RDAT_W; // 13
  localparam int SPAN_LSB  = 10;
  localparam int CRC_LSB   = SPAN_LSB - CRC_W; // 2
  localparam int SPAN_W    = WORD_W - SPAN_LSB; // 22
  localparam int SPAN_PAD  = 3 * CRC_W;        // three bytes

  localparam int ADDR_W    = REG_W;
  localparam int DATA_W    = CONV_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;
  localparam int CELL_LAST = 5;

  typedef enum logic {
    FMT_CONV = 1'b0,
    FMT_REG  = 1'b1
  } rsp_fmt_e;

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              is_cell;
  } rsp_fields_t;

  // Table entry: remainder of one byte divided by the generator, zero start.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = b;
    for (int i = 0; i < CRC_W; i++) begin
      if (r[CRC_W-1]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else            r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/rsp_crc_check.sv
module rsp_crc_check
  import rsp_chk_pkg::*;
(
  input  logic [WORD_W-1:CRC_LSB] word_hi,
  output logic [CRC_W-1:0]        crc_calc,
  output logic                    crc_bad
);

  logic [SPAN_PAD-1:0] span_pad;
  logic [CRC_W-1:0]    byte_top;
  logic [CRC_W-1:0]    byte_mid;
  logic [CRC_W-1:0]    byte_low;
  logic [CRC_W-1:0]    stage_a;
  logic [CRC_W-1:0]    stage_b;
  logic [CRC_W-1:0]    crc_rx;

  assign span_pad = {{(SPAN_PAD-SPAN_W){1'b0}}, word_hi[WORD_W-1:SPAN_LSB]};
  assign byte_top = span_pad[2*CRC_W +: CRC_W];
  assign byte_mid = span_pad[CRC_W   +: CRC_W];
  assign byte_low = span_pad[0       +: CRC_W];
  assign crc_rx   = word_hi[CRC_LSB +: CRC_W];

  // Two cascaded byte lookups, then a plain XOR of the lowest byte.
  always_comb begin
    stage_a  = crc_byte(byte_top);
    stage_b  = crc_byte(stage_a ^ byte_mid);
    crc_calc = stage_b ^ byte_low;
    crc_bad  = (crc_calc != crc_rx);
  end

endmodule

// File: rtl/rsp_dev_reverse.sv
module rsp_dev_reverse #(
  parameter int W = 5
) (
  input  logic [W-1:0] wire_addr,
  output logic [W-1:0] logic_addr
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign logic_addr[i] = wire_addr[W-1-i];
  end

endmodule

// File: rtl/rsp_field_decode.sv
module rsp_field_decode
  import rsp_chk_pkg::*;
(
  input  logic [WORD_W-1:CONV_LSB] hdr,
  input  rsp_fmt_e                 fmt,
  input  logic [DEV_W-1:0]         exp_dev,
  input  logic [ADDR_W-1:0]        exp_addr,
  output rsp_fields_t              fields,
  output logic                     mismatch
);

  logic [DEV_W-1:0]  dev_wire;
  logic [DEV_W-1:0]  dev_log;
  logic [CH_W-1:0]   ch_code;
  logic [REG_W-1:0]  reg_addr;
  logic [CONV_W-1:0] conv_val;
  logic [RDAT_W-1:0] reg_val;
  logic              sub_ok;

  assign dev_wire = hdr[DEV_LSB  +: DEV_W];
  assign ch_code  = hdr[CH_LSB   +: CH_W];
  assign reg_addr = hdr[REG_LSB  +: REG_W];
  assign conv_val = hdr[CONV_LSB +: CONV_W];
  assign reg_val  = hdr[RDAT_LSB +: RDAT_W];

  rsp_dev_reverse #(.W(DEV_W)) u_rev (
    .wire_addr  (dev_wire),
    .logic_addr (dev_log)
  );

  always_comb begin
    fields.dev = dev_log;
    if (fmt == FMT_REG) begin
      fields.addr    = reg_addr;
      fields.data    = DATA_W'(reg_val);
      fields.is_cell = 1'b0;
      sub_ok         = (reg_addr == exp_addr);
    end else begin
      fields.addr    = ADDR_W'(ch_code);
      fields.data    = conv_val;
      fields.is_cell = (ch_code <= CH_W'(CELL_LAST));
      sub_ok         = (ch_code == exp_addr[CH_W-1:0]);
    end
    mismatch = (dev_log != exp_dev) || !sub_ok;
  end

endmodule

// File: rtl/rsp_word_checker.sv
module rsp_word_checker
  import rsp_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [31:0]       word_in,
  input  logic              fmt_reg,
  input  logic [4:0]        exp_dev,
  input  logic [5:0]        exp_addr,
  output logic              res_vld,
  output logic              crc_err,
  output logic              addr_err,
  output logic [4:0]        dev_addr,
  output logic [5:0]        sub_addr,
  output logic [11:0]       data,
  output logic              is_cell
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Bits below the check field carry nothing this block uses.
  logic unused_tail;
  assign unused_tail = ^word_in[CRC_LSB-1:0];

  logic [CRC_W-1:0] crc_calc;
  logic             crc_bad;
  rsp_fields_t      dec_fields;
  logic             dec_mismatch;
  rsp_fmt_e         fmt_sel;

  assign fmt_sel = rsp_fmt_e'(fmt_reg);

  rsp_crc_check u_crc (
    .word_hi  (word_in[WORD_W-1:CRC_LSB]),
    .crc_calc (crc_calc),
    .crc_bad  (crc_bad)
  );

  rsp_field_decode u_dec (
    .hdr      (word_in[WORD_W-1:CONV_LSB]),
    .fmt      (fmt_sel),
    .exp_dev  (exp_dev),
    .exp_addr (exp_addr),
    .fields   (dec_fields),
    .mismatch (dec_mismatch)
  );

  logic unused_calc;
  assign unused_calc = ^crc_calc;

  // Next state
  logic        vld_d, crc_err_d, addr_err_d, fld_en;
  rsp_fields_t fld_d;
  logic        vld_q, crc_err_q, addr_err_q;
  rsp_fields_t fld_q;

  always_comb begin
    vld_d      = word_vld;
    crc_err_d  = word_vld && crc_bad;
    addr_err_d = word_vld && !crc_bad && dec_mismatch;
    fld_en     = word_vld;
    fld_d      = crc_bad ? '0 : dec_fields;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q      <= 1'b0;
      crc_err_q  <= 1'b0;
      addr_err_q <= 1'b0;
      fld_q      <= '0;
    end else begin
      vld_q      <= vld_d;
      crc_err_q  <= crc_err_d;
      addr_err_q <= addr_err_d;
      if (fld_en) fld_q <= fld_d;
    end
  end

  assign res_vld  = vld_q;
  assign crc_err  = crc_err_q;
  assign addr_err = addr_err_q;
  assign dev_addr = fld_q.dev;
  assign sub_addr = fld_q.addr;
  assign data     = fld_q.data;
  assign is_cell  = fld_q.is_cell;

  // Assertions
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    word_vld |=> res_vld);

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !word_vld |=> !res_vld);

  a_r10_flags_qualified: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (crc_err || addr_err) |-> res_vld);

  a_r4_crc_suppress: assert property (@(posedge clk) disable iff (!rst_sync_n)
    crc_err |-> (!addr_err && !is_cell && data == '0 && sub_addr == '0 && dev_addr == '0));

  a_r9_cell_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_cell |-> (sub_addr <= 6'(CELL_LAST) && !crc_err));

  a_r5_dev_reversed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_vld && !crc_err) |-> (dev_addr == {$past(word_in[27]), $past(word_in[28]),
                                            $past(word_in[29]), $past(word_in[30]),
                                            $past(word_in[31])}));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !word_vld |=> ($stable(data) && $stable(sub_addr) && $stable(dev_addr)));

endmodule

// File: tb/rsp_word_checker_bench.sv
`timescale 1ns/1ps
module rsp_word_checker_bench;

  logic        clk;
  logic        rst_n;
  logic        word_vld;
  logic [31:0] word_in;
  logic        fmt_reg;
  logic [4:0]  exp_dev;
  logic [5:0]  exp_addr;
  logic        res_vld, crc_err, addr_err, is_cell;
  logic [4:0]  dev_addr;
  logic [5:0]  sub_addr;
  logic [11:0] data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  rsp_word_checker u_rsp_word_checker (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
    .fmt_reg(fmt_reg), .exp_dev(exp_dev), .exp_addr(exp_addr),
    .res_vld(res_vld), .crc_err(crc_err), .addr_err(addr_err),
    .dev_addr(dev_addr), .sub_addr(sub_addr), .data(data), .is_cell(is_cell)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  function automatic logic [4:0] to_wire(input logic [4:0] a);
    return {a[0], a[1], a[2], a[3], a[4]};
  endfunction

  function automatic logic [7:0] ref_crc(input logic [21:0] m);
    logic [7:0] c = 8'h00;
    for (int i = 21; i >= 8; i--) begin
      logic fb = c[7] ^ m[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h2F;
    end
    return c ^ m[7:0];
  endfunction

  function automatic logic [31:0] seal(input logic [31:0] w);
    logic [31:0] r = w;
    r[9:2] = ref_crc(w[31:10]);
    return r;
  endfunction

  function automatic logic [31:0] conv_word(input logic [4:0] dev, input logic [3:0] ch,
                                            input logic [11:0] v);
    return seal({to_wire(dev), ch, v, 11'b0});
  endfunction

  function automatic logic [31:0] reg_word(input logic [4:0] dev, input logic [5:0] ra,
                                           input logic [7:0] d);
    return seal({to_wire(dev), ra, d, 13'b0});
  endfunction

  task automatic present(input logic [31:0] w, input logic f, input logic [4:0] ed,
                         input logic [5:0] ea);
    word_vld = 1'b1; word_in = w; fmt_reg = f; exp_dev = ed; exp_addr = ea;
  endtask

  task automatic expect_out(input string tag, input logic v, input logic ce, input logic ae,
                            input logic [4:0] d, input logic [5:0] a, input logic [11:0] x,
                            input logic c);
    check({tag, " res_vld"},  32'(res_vld),  32'(v));
    check({tag, " crc_err"},  32'(crc_err),  32'(ce));
    check({tag, " addr_err"}, 32'(addr_err), 32'(ae));
    check({tag, " dev_addr"}, 32'(dev_addr), 32'(d));
    check({tag, " sub_addr"}, 32'(sub_addr), 32'(a));
    check({tag, " data"},     32'(data),     32'(x));
    check({tag, " is_cell"},  32'(is_cell),  32'(c));
  endtask

  // One word in, result checked one cycle later.
  task automatic one_word(input string tag, input logic [31:0] w, input logic f,
                          input logic [4:0] ed, input logic [5:0] ea,
                          input logic ce, input logic ae, input logic [4:0] d,
                          input logic [5:0] a, input logic [11:0] x, input logic c);
    @(negedge clk);
    present(w, f, ed, ea);
    @(negedge clk);
    word_vld = 1'b0;
    expect_out(tag, 1'b1, ce, ae, d, a, x, c);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; word_vld = 1'b0; word_in = '0; fmt_reg = 1'b0;
    exp_dev = '0; exp_addr = '0;
    repeat (3) @(negedge clk);
    expect_out("R1 in-reset", 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R1 after-reset", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_conv_cell;
    one_word("R6 conv cell3", conv_word(5'd3, 4'd3, 12'hA5C), 1'b0, 5'd3, 6'd3,
             0, 0, 5'd3, 6'd3, 12'hA5C, 1);
  endtask

  task automatic t_cell_boundary;
    one_word("R9 ch5", conv_word(5'd1, 4'd5, 12'h001), 1'b0, 5'd1, 6'd5,
             0, 0, 5'd1, 6'd5, 12'h001, 1);
    one_word("R9 ch6", conv_word(5'd1, 4'd6, 12'hFFF), 1'b0, 5'd1, 6'd6,
             0, 0, 5'd1, 6'd6, 12'hFFF, 0);
    one_word("R9 ch11", conv_word(5'd1, 4'd11, 12'h800), 1'b0, 5'd1, 6'd11,
             0, 0, 5'd1, 6'd11, 12'h800, 0);
    one_word("R9 ch0", conv_word(5'd0, 4'd0, 12'h000), 1'b0, 5'd0, 6'd0,
             0, 0, 5'd0, 6'd0, 12'h000, 1);
  endtask

  task automatic t_reversal;
    // logical 00011 goes out on the wire as 11000
    one_word("R5 asym dev", conv_word(5'b00011, 4'd2, 12'h123), 1'b0, 5'b00011, 6'd2,
             0, 0, 5'b00011, 6'd2, 12'h123, 1);
    one_word("R5 dev 10110", reg_word(5'b10110, 6'h1C, 8'h3C), 1'b1, 5'b10110, 6'h1C,
             0, 0, 5'b10110, 6'h1C, 12'h03C, 0);
  endtask

  task automatic t_addr_mismatch;
    one_word("R8 dev mismatch", conv_word(5'd4, 4'd1, 12'h456), 1'b0, 5'd5, 6'd1,
             0, 1, 5'd4, 6'd1, 12'h456, 1);
    one_word("R8 ch mismatch", conv_word(5'd4, 4'd7, 12'h456), 1'b0, 5'd4, 6'd8,
             0, 1, 5'd4, 6'd7, 12'h456, 0);
    // conversion layout ignores exp_addr[5:4]
    one_word("R8 conv upper ignored", conv_word(5'd4, 4'd2, 12'h777), 1'b0, 5'd4, 6'h32,
             0, 0, 5'd4, 6'd2, 12'h777, 1);
    // register layout compares all six bits
    one_word("R8 reg upper mismatch", reg_word(5'd4, 6'h02, 8'h99), 1'b1, 5'd4, 6'h32,
             0, 1, 5'd4, 6'h02, 12'h099, 0);
  endtask

  task automatic t_register;
    one_word("R7 reg readback", reg_word(5'd7, 6'h0E, 8'hD1), 1'b1, 5'd7, 6'h0E,
             0, 0, 5'd7, 6'h0E, 12'h0D1, 0);
    one_word("R7 reg max", reg_word(5'd31, 6'h3F, 8'hFF), 1'b1, 5'd31, 6'h3F,
             0, 0, 5'd31, 6'h3F, 12'h0FF, 0);
  endtask

  task automatic t_crc;
    logic [31:0] w;
    w = conv_word(5'd2, 4'd4, 12'hC3A);
    one_word("R3 crc bit9 flip", w ^ 32'h0000_0200, 1'b0, 5'd9, 6'd9,
             1, 0, 0, 0, 0, 0);
    one_word("R3 crc data flip", w ^ 32'h0000_8000, 1'b0, 5'd2, 6'd4,
             1, 0, 0, 0, 0, 0);
    one_word("R4 crc top flip", w ^ 32'h8000_0000, 1'b0, 5'd2, 6'd4,
             1, 0, 0, 0, 0, 0);
    one_word("R3 low bits free", w | 32'h0000_0003, 1'b0, 5'd2, 6'd4,
             0, 0, 5'd2, 6'd4, 12'hC3A, 1);
    one_word("R3 bit10 free", w ^ 32'h0000_0400 ^ {22'b0, (ref_crc((w ^ 32'h400) >> 10) ^ w[9:2]), 2'b0},
             1'b0, 5'd2, 6'd4, 0, 0, 5'd2, 6'd4, 12'hC3A, 1);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    present(conv_word(5'd6, 4'd1, 12'h111), 1'b0, 5'd6, 6'd1);
    @(negedge clk);
    expect_out("R2 b2b first", 1, 0, 0, 5'd6, 6'd1, 12'h111, 1);
    present(reg_word(5'd6, 6'h15, 8'h22), 1'b1, 5'd6, 6'h15);
    @(negedge clk);
    expect_out("R2 b2b second", 1, 0, 0, 5'd6, 6'h15, 12'h022, 0);
    word_vld = 1'b0;
    word_in = 32'hFFFF_FFFF;
    @(negedge clk);
    expect_out("R10 idle hold", 0, 0, 0, 5'd6, 6'h15, 12'h022, 0);
  endtask

  task automatic t_flag_drop;
    logic [31:0] w;
    w = conv_word(5'd1, 4'd1, 12'h0F0) ^ 32'h4;
    @(negedge clk);
    present(w, 1'b0, 5'd1, 6'd1);
    @(negedge clk);
    word_vld = 1'b0;
    expect_out("R4 crc fail", 1, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expect_out("R10 crc flag drops", 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_conv_cell();
    t_cell_boundary();
    t_reversal();
    t_addr_mismatch();
    t_register();
    t_crc();
    t_back_to_back();
    t_flag_drop();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule